// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block turns one captured word address into the array addresses of a four-beat burst. When the load strobe is accepted the whole address is registered. The upper bits stay fixed until the next load. The two low bits then step through one of two beat orders each time the active-low advance input is sampled low.

The two orders are an XOR-style interleave and a linear count that wraps modulo four. The order select is treated as a static strap and is latched on every load. Holding advance high suspends the burst on its current beat. After the fourth beat, the next advance returns the burst to its starting address.

A beat index output reports how many advances have occurred since the load, modulo four. Arbitration between address strobes, chip-select decoding, data storage and output buffering live outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous active-high reset is sampled high, the array address and the beat index are cleared to zero at the clock edge.
- R2: A high load strobe at a rising edge captures the full load address, so the array address equals it in the following cycle. The beat index becomes 0, and the advance input is ignored in that cycle.
- R3: The address bits above the two low bits keep the value captured at load until the next load.
- R4: With the order select latched as 1 (interleaved), beat k drives low bits equal to start XOR k. The sequences are 00-01-10-11 from 00, 01-00-11-10 from 01, 10-11-00-01 from 10, and 11-10-01-00 from 11.
- R5: With the order select latched as 0 (linear), beat k drives low bits equal to (start + k) mod 4. The sequences are 00-01-10-11 from 00, 01-10-11-00 from 01, 10-11-00-01 from 10, and 11-00-01-10 from 11.
- R6: The advance input is active low and is sampled at the rising edge. When it is low and load is low, the beat index increments by one, and the array address moves to the next beat of the latched order.
- R7: When advance is high and load is low, both the array address and the beat index hold their values, which suspends the burst.
- R8: An advance taken on beat 3 wraps the burst. The beat index returns to 0 and the array address returns to the address captured at load.
- R9: The order select is sampled only on a load. Changing it during a burst does not alter the sequence until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe, active high; captures load_addr |
| load_addr | input | ADDR_W (16) | Word address presented with load |
| adv_n | input | 1 | Advance enable, active low |
| order_ilv | input | 1 | Order strap: 1 interleaved, 0 linear |
| array_addr | output | ADDR_W (16) | Current array address of the burst |
| beat_idx | output | CNT_W (2) | Beats advanced since load, modulo four |

## Verification
The bench builds the block with its defaults: a 16-bit address and a two-bit burst counter. With these values a full wrap takes only four advances, and every one of the four start values in both orders is reached by random loads within a few hundred cycles. The 14 fixed upper bits make any leakage of a carry out of the low field visible. The random traffic loads, advances, suspends and flips the order strap in the middle of bursts. Directed walks pin down a load taken while advance is low, the wrap after beat 3, a long suspend, and a strap change during a burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    localparam int BURST_CNT_W_DEF = 2;
    localparam int BURST_ADDR_W_DEF = 16;

    // Linear successor of a beat value inside a field of width w (w <= 8).
    function automatic logic [7:0] wrap_add(input logic [7:0] a,
                                            input logic [7:0] b,
                                            input int unsigned w);
        logic [7:0] mask;
        mask = 8'((9'd1 << w) - 9'd1);
        return (a + b) & mask;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              order_ilv,
    output logic [ADDR_W-CNT_W-1:0] upper,
    output logic [CNT_W-1:0]  start_lo,
    output order_e            ord
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UP_W-1:0]  upper;
        logic [CNT_W-1:0] start;
        order_e           ord;
    } base_t;

    base_t base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '{upper: '0, start: '0, ord: ORD_INTERLEAVE};
        end else if (load) begin
            base_q.upper <= load_addr[ADDR_W-1:CNT_W];
            base_q.start <= load_addr[CNT_W-1:0];
            base_q.ord   <= order_e'(order_ilv);
        end
    end

    assign upper    = base_q.upper;
    assign start_lo = base_q.start;
    assign ord      = base_q.ord;

    // R9: the latched order only moves on a load
    assert_order_latched_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ord));

    // R3: upper field frozen between loads
    assert_upper_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(upper));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv_n,
    output logic [CNT_W-1:0] beat
);
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RESTART,
        ACT_STEP
    } beat_act_e;

    logic [CNT_W-1:0] beat_q;
    beat_act_e        act;

    always_comb begin
        if (load)        act = ACT_RESTART;
        else if (!adv_n) act = ACT_STEP;
        else             act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            case (act)
                ACT_RESTART: beat_q <= '0;
                ACT_STEP:    beat_q <= beat_q + 1'b1;
                default:     beat_q <= beat_q;
            endcase
        end
    end

    assign beat = beat_q;

    // R6: one step per sampled-low advance
    assert_beat_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n) |=> beat == CNT_W'($past(beat) + 1'b1));

    // R7: no step while suspended
    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> $stable(beat));

    // R2: load restarts the count even with advance asserted
    assert_beat_restart_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> beat == '0);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  order_e           ord,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low
);
    logic [CNT_W-1:0] ilv_low;
    logic [CNT_W-1:0] lin_low;

    genvar b;
    generate
        for (b = 0; b < CNT_W; b++) begin : g_ilv_bit
            assign ilv_low[b] = start[b] ^ beat[b];
        end
    endgenerate

    assign lin_low = CNT_W'(wrap_add(8'(start), 8'(beat), CNT_W));

    assign low = (ord == ORD_INTERLEAVE) ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = BURST_ADDR_W_DEF,
    parameter int CNT_W  = BURST_CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              adv_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] array_addr,
    output logic [CNT_W-1:0]  beat_idx
);
    localparam int UP_W  = ADDR_W - CNT_W;
    localparam int BEATS = 1 << CNT_W;

    logic [UP_W-1:0]  upper;
    logic [CNT_W-1:0] start_lo;
    logic [CNT_W-1:0] low;
    logic [CNT_W-1:0] beat;
    order_e           ord;

    burst_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (load_addr),
        .order_ilv (order_ilv),
        .upper     (upper),
        .start_lo  (start_lo),
        .ord       (ord)
    );

    burst_beat_ctr #(.CNT_W(CNT_W)) u_beat (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv_n (adv_n),
        .beat  (beat)
    );

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .ord   (ord),
        .start (start_lo),
        .beat  (beat),
        .low   (low)
    );

    assign array_addr = {upper, low};
    assign beat_idx   = beat;

    // R2: whole address visible one cycle after load
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (array_addr == $past(load_addr) && beat_idx == '0));

    // R7: suspended burst keeps its address
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> $stable(array_addr));

    // R8: advance from the last beat returns to the start
    assert_wrap_start_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n && beat_idx == CNT_W'(BEATS - 1))
        |=> (beat_idx == '0 && array_addr[CNT_W-1:0] == start_lo));

    // R4/R5: beat 0 always presents the start bits in either order
    assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
        beat_idx == '0 |-> array_addr[CNT_W-1:0] == start_lo);

endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [15:0] load_addr;
    logic        adv_n;
    logic        order_ilv;
    logic [15:0] array_addr;
    logic [1:0]  beat_idx;

    int checks = 0;
    int failures = 0;

    logic [13:0] m_upper;
    logic [1:0]  m_start;
    logic [1:0]  m_beat;
    logic        m_ilv;

    always #10 clk = ~clk;

    burst_addr_gen uut (
        .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
        .adv_n(adv_n), .order_ilv(order_ilv),
        .array_addr(array_addr), .beat_idx(beat_idx)
    );

    // Expected low bits, taken from the sequence lists in R4 and R5
    function automatic logic [1:0] exp_low(input logic [1:0] s,
                                           input logic [1:0] k,
                                           input logic ilv);
        logic [1:0] seq [4];
        if (!ilv) return 2'(s + k);
        case (s)
            2'd0: seq = '{2'd0, 2'd1, 2'd2, 2'd3};
            2'd1: seq = '{2'd1, 2'd0, 2'd3, 2'd2};
            2'd2: seq = '{2'd2, 2'd3, 2'd0, 2'd1};
            default: seq = '{2'd3, 2'd2, 2'd1, 2'd0};
        endcase
        return seq[k];
    endfunction

    task automatic check(input string tag);
        logic [15:0] ea;
        ea = {m_upper, exp_low(m_start, m_beat, m_ilv)};
        checks++;
        if (array_addr !== ea || beat_idx !== m_beat) begin
            failures++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, array_addr, beat_idx, ea, m_beat);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, update model, check
    task automatic cyc(input logic r, input logic ld, input logic [15:0] a,
                       input logic an, input logic m, input string tag);
        rst = r; load = ld; load_addr = a; adv_n = an; order_ilv = m;
        @(posedge clk);
        if (r) begin
            m_upper = '0; m_start = '0; m_beat = '0; m_ilv = 1'b1;
        end else if (ld) begin
            m_upper = a[15:2]; m_start = a[1:0]; m_beat = '0; m_ilv = m;
        end else if (!an) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(20ns * 100000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        rst = 1'b1; load = 1'b0; load_addr = 16'h0; adv_n = 1'b1; order_ilv = 1'b1;
        @(negedge clk);
        // R1: reset clears address and beat, even with load and advance asserted
        cyc(1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0, "R1");
        cyc(1'b1, 1'b0, 16'h0, 1'b0, 1'b1, "R1");

        // R2: load with advance low, advance ignored in the load cycle
        cyc(1'b0, 1'b1, 16'hA5C1, 1'b0, 1'b1, "R2");
        // R4 + R6 + R8: interleaved walk from 01 and wrap
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R4");
        cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R6");

        // R5: linear walk from 11, then wrap
        cyc(1'b0, 1'b1, 16'h3337, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R5");
        cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R8");

        // R7: suspend for several cycles mid-burst
        cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, "R7");

        // R9: strap flips mid-burst, sequence keeps the latched order
        cyc(1'b0, 1'b1, 16'h7F02, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R9");

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic ld, an, m;
            logic [15:0] a;
            ld = ($urandom % 5) == 0;
            an = ($urandom % 3) == 0;
            m  = $urandom % 2;
            a  = 16'($urandom);
            cyc(1'b0, ld, a, an, m, m_ilv ? "R4" : "R5");
            checks++;
            if (array_addr[15:2] !== m_upper) begin
                failures++;
                $display("FAIL R3: upper=%h expected %h", array_addr[15:2], m_upper);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule